// File: doc/BRIEF.md
# Divergent Warp Compaction Controller

This block sits beside a SIMD warp scheduler. It gathers the threads of several warps that have split at the same conditional branch and packs them into fewer and fuller issue groups, one set for the taken path and one set for the fall-through path. Each warp reaches the branch with a one-cycle `arr_valid` pulse and two active-lane masks. A warp whose active threads all go the same way skips the gather and is reported as bypassed. A warp that has threads on both paths is held with `stall_o` until the gather fires.

The gather fires in one of two cases. Either every warp named in `grp_member` has reached the branch, or the waiting time has run out. When it fires, the block counts the issue groups that packing would need. If packing would not issue fewer groups than the waiting warps would issue on their own, the gather is cancelled and those warps go out uncompacted. A waiting set is also released, uncompacted, when no warp outside it is ready to issue. The packed result names the source warp and the source lane of every slot, so that the results can be scattered back.

Top module: `ws_compaction_ctrl`

## Requirements
- R1: A warp that arrives with an all-zero taken mask or an all-zero fall-through mask is uniform. It receives a `bypass_pls` bit in the cycle after its arrival edge and never raises `stall_o`.
- R2: A warp that arrives with bits set in both masks is divergent. Its `stall_o` bit is high from the cycle after arrival until the gather fires or the set is released.
- R3: The gather fires once every warp in `grp_member` has arrived, counting bypassed warps. The packed result appears with `cmp_valid` one cycle after the last arrival. It never fires earlier, unless the timeout expires.
- R4: Packed slot s belongs to group s/8 and lane s%8. Slots are filled without gaps, in increasing warp index and then increasing lane index. Each filled slot carries a 2-bit warp ID and a 3-bit lane ID, at slot s of `*_warp` bits [2s+1:2s] and of `*_lane` bits [3s+2:3s]. Input lane l of warp w is mask bit 8w+l.
- R5: For each path, the group count equals the number of active threads of the waiting warps on that path, divided by 8 and rounded up.
- R6: A gather is cancelled when the two group counts together are at least twice the number of waiting warps. A cancelled gather gives `cancel_pls` set for exactly those warps, with `cmp_valid` low.
- R7: While warps are waiting and the gather does not fire, the waiting set is released when `ready_vec` has no bit set outside that set. Release gives `release_pls` for the waiting warps one cycle later and clears their stall.
- R8: With WAIT_LIMIT=16, a set that is still incomplete fires 16 cycles after the first divergent arrival.
- R9: `bypass_pls`, `cancel_pls`, `release_pls` and `cmp_valid` last one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | 4 | One-cycle arrival pulse per warp |
| arr_taken | input | 32 | Taken-path active lanes, warp w at bits 8w+7:8w |
| arr_fall | input | 32 | Fall-through active lanes, same layout |
| grp_member | input | 4 | Warps that belong to the current gather |
| ready_vec | input | 4 | Warps the scheduler could issue now |
| stall_o | output | 4 | Warp held at the gather point |
| bypass_pls | output | 4 | Uniform warp skipped the gather |
| cancel_pls | output | 4 | Gather cancelled, warp issues uncompacted |
| release_pls | output | 4 | Waiting warp released for lack of other work |
| cmp_valid | output | 1 | Packed result valid |
| cmp_warps | output | 4 | Warps folded into the packed result |
| tk_vld | output | 32 | Taken-path slot occupied |
| tk_warp | output | 64 | Taken-path slot source warp |
| tk_lane | output | 96 | Taken-path slot source lane |
| tk_groups | output | 3 | Taken-path group count |
| fl_vld | output | 32 | Fall-through slot occupied |
| fl_warp | output | 64 | Fall-through slot source warp |
| fl_lane | output | 96 | Fall-through slot source lane |
| fl_groups | output | 3 | Fall-through group count |

## Verification
The bench drives several kinds of warp set. An all-uniform set should only give bypass pulses and must not stall anything. A single divergent warp can never save a group, so it always cancels. Four warps with complementary half masks fill whole groups with no gaps, which shows the slot ordering and the rounding. Pseudo-random member sets mix uniform and divergent warps with uneven masks, and their slot contents and cancel decisions are compared with a model in the bench. Two waiting scenarios tell the exits apart: in one, the ready vector empties and the set is released; in the other, a member never arrives and the timeout fires.

// File: rtl/ws_pkg.sv
// Package ws_pkg
// Shared helpers for the warp compaction controller.
// Assumes: operands are small non-negative counts.
package ws_pkg;
    // Integer division of a by b, rounded up.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/ws_compactor.sv
// Module ws_compactor
// Packs the set bits of a warp-major lane mask into consecutive slots.
// Bit w*LANES+l goes to the next free slot, and that slot records w and l.
// It also gives the number of LANES-wide groups that the slots fill.
// Assumes: purely combinational; the caller registers the outputs.
module ws_compactor #(
    parameter int NUM_WARPS = 4,
    parameter int LANES     = 8
) (
    input  logic [NUM_WARPS*LANES-1:0]                   mask_i,
    output logic [NUM_WARPS*LANES-1:0]                   slot_vld_o,
    output logic [NUM_WARPS*LANES*$clog2(NUM_WARPS)-1:0] slot_warp_o,
    output logic [NUM_WARPS*LANES*$clog2(LANES)-1:0]     slot_lane_o,
    output logic [$clog2(NUM_WARPS+1)-1:0]               groups_o
);
    localparam int NT = NUM_WARPS * LANES;
    localparam int WB = $clog2(NUM_WARPS);
    localparam int LB = $clog2(LANES);
    localparam int GW = $clog2(NUM_WARPS + 1);

    // Walk the mask and put each active thread in the next free slot.
    always_comb begin
        int k;
        k = 0;
        slot_vld_o  = '0;
        slot_warp_o = '0;
        slot_lane_o = '0;
        for (int i = 0; i < NT; i++) begin
            if (mask_i[i]) begin
                slot_vld_o[k]            = 1'b1;
                slot_warp_o[k*WB +: WB]  = WB'(i / LANES);
                slot_lane_o[k*LB +: LB]  = LB'(i % LANES);
                k = k + 1;
            end
        end
        groups_o = GW'(ws_pkg::ceil_div(k, LANES));
    end
endmodule

// File: rtl/ws_wait_timer.sv
// Module ws_wait_timer
// Counts the cycles during which a gather is waiting. expired_o goes high
// when the count reaches LIMIT-1 while run_i is still asserted.
// Assumes: clear_i has priority; the count saturates at LIMIT-1.
module ws_wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    logic [CW-1:0] cnt_q;

    // Advance the wait count; restart it when idle or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !run_i)
            cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT - 1))
            cnt_q <= cnt_q + 1'b1;
    end

    // Expiry flag for the current wait.
    always_comb expired_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ws_compaction_ctrl.sv
// Module ws_compaction_ctrl
// Gathers divergent warps at a branch and packs their threads per path.
// Uniform warps bypass. A gather is cancelled when it would not reduce
// the number of issue groups. A waiting set is released when nothing
// else can issue, and a timeout fires a set that stays incomplete.
// Assumes: at most one arrival per warp per gather; grp_member is held
// stable during a gather; the taken and fall masks of a warp are disjoint.
module ws_compaction_ctrl #(
    parameter int NUM_WARPS  = 4,
    parameter int LANES      = 8,
    parameter int WAIT_LIMIT = 16
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_WARPS-1:0]                          arr_valid,
    input  logic [NUM_WARPS*LANES-1:0]                    arr_taken,
    input  logic [NUM_WARPS*LANES-1:0]                    arr_fall,
    input  logic [NUM_WARPS-1:0]                          grp_member,
    input  logic [NUM_WARPS-1:0]                          ready_vec,
    output logic [NUM_WARPS-1:0]                          stall_o,
    output logic [NUM_WARPS-1:0]                          bypass_pls,
    output logic [NUM_WARPS-1:0]                          cancel_pls,
    output logic [NUM_WARPS-1:0]                          release_pls,
    output logic                                          cmp_valid,
    output logic [NUM_WARPS-1:0]                          cmp_warps,
    output logic [NUM_WARPS*LANES-1:0]                    tk_vld,
    output logic [NUM_WARPS*LANES*$clog2(NUM_WARPS)-1:0]  tk_warp,
    output logic [NUM_WARPS*LANES*$clog2(LANES)-1:0]      tk_lane,
    output logic [$clog2(NUM_WARPS+1)-1:0]                tk_groups,
    output logic [NUM_WARPS*LANES-1:0]                    fl_vld,
    output logic [NUM_WARPS*LANES*$clog2(NUM_WARPS)-1:0]  fl_warp,
    output logic [NUM_WARPS*LANES*$clog2(LANES)-1:0]      fl_lane,
    output logic [$clog2(NUM_WARPS+1)-1:0]                fl_groups
);
    localparam int NT = NUM_WARPS * LANES;
    localparam int WB = $clog2(NUM_WARPS);
    localparam int LB = $clog2(LANES);
    localparam int GW = $clog2(NUM_WARPS + 1);

    logic [NUM_WARPS-1:0] pending_q, arrived_q;
    logic [NT-1:0]        tk_mask_q, fl_mask_q;
    logic [NUM_WARPS-1:0] uniform, divergent;
    logic [NT-1:0]        tk_sel, fl_sel;
    logic [NT-1:0]        c_tk_vld, c_fl_vld;
    logic [NT*WB-1:0]     c_tk_warp, c_fl_warp;
    logic [NT*LB-1:0]     c_tk_lane, c_fl_lane;
    logic [GW-1:0]        c_tk_grp, c_fl_grp;
    logic                 waiting, all_in, expired;
    logic                 fire, release_now, cancel_now, clr_round;

    // Classify each arriving warp as uniform or divergent.
    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            uniform[w]   = arr_valid[w] && ((arr_taken[w*LANES +: LANES] == '0) ||
                                            (arr_fall[w*LANES +: LANES] == '0));
            divergent[w] = arr_valid[w] && !uniform[w];
        end
    end

    // Pass only the lanes of warps that are waiting to the packers.
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_sel
        assign tk_sel[g*LANES +: LANES] = pending_q[g] ? tk_mask_q[g*LANES +: LANES] : '0;
        assign fl_sel[g*LANES +: LANES] = pending_q[g] ? fl_mask_q[g*LANES +: LANES] : '0;
    end

    // One packer per branch path.
    for (genvar p = 0; p < 2; p++) begin : g_path
        if (p == 0) begin : g_tk
            ws_compactor #(.NUM_WARPS(NUM_WARPS), .LANES(LANES)) u_pack (
                .mask_i(tk_sel), .slot_vld_o(c_tk_vld), .slot_warp_o(c_tk_warp),
                .slot_lane_o(c_tk_lane), .groups_o(c_tk_grp));
        end else begin : g_fl
            ws_compactor #(.NUM_WARPS(NUM_WARPS), .LANES(LANES)) u_pack (
                .mask_i(fl_sel), .slot_vld_o(c_fl_vld), .slot_warp_o(c_fl_warp),
                .slot_lane_o(c_fl_lane), .groups_o(c_fl_grp));
        end
    end

    // Waiting-time guard for the gather.
    ws_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(waiting),
        .clear_i(fire || release_now), .expired_o(expired));

    // Decide between fire, cancel and release for this cycle.
    always_comb begin
        int npend;
        npend = 0;
        for (int w = 0; w < NUM_WARPS; w++) npend = npend + int'(pending_q[w]);
        waiting     = (pending_q != '0);
        all_in      = ((arrived_q & grp_member) == grp_member);
        fire        = waiting && (all_in || expired);
        release_now = waiting && !fire && ((ready_vec & ~pending_q) == '0);
        cancel_now  = fire && ((int'(c_tk_grp) + int'(c_fl_grp)) >= 2 * npend);
        clr_round   = fire || release_now || (!waiting && all_in);
    end

    // Track waiting and arrived warps, and keep the masks of divergent ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            arrived_q <= '0;
            tk_mask_q <= '0;
            fl_mask_q <= '0;
        end else begin
            pending_q <= ((fire || release_now) ? '0 : (pending_q & ~arr_valid)) | divergent;
            arrived_q <= (clr_round ? '0 : arrived_q) | arr_valid;
            for (int w = 0; w < NUM_WARPS; w++) begin
                if (divergent[w]) begin
                    tk_mask_q[w*LANES +: LANES] <= arr_taken[w*LANES +: LANES];
                    fl_mask_q[w*LANES +: LANES] <= arr_fall[w*LANES +: LANES];
                end
            end
        end
    end

    // Register the decisions as one-cycle pulses and the packed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass_pls  <= '0;
            cancel_pls  <= '0;
            release_pls <= '0;
            cmp_valid   <= 1'b0;
            cmp_warps   <= '0;
            tk_vld <= '0; tk_warp <= '0; tk_lane <= '0; tk_groups <= '0;
            fl_vld <= '0; fl_warp <= '0; fl_lane <= '0; fl_groups <= '0;
        end else begin
            bypass_pls  <= uniform;
            cancel_pls  <= cancel_now ? pending_q : '0;
            release_pls <= release_now ? pending_q : '0;
            cmp_valid   <= fire && !cancel_now;
            cmp_warps   <= (fire && !cancel_now) ? pending_q : '0;
            if (fire && !cancel_now) begin
                tk_vld <= c_tk_vld; tk_warp <= c_tk_warp;
                tk_lane <= c_tk_lane; tk_groups <= c_tk_grp;
                fl_vld <= c_fl_vld; fl_warp <= c_fl_warp;
                fl_lane <= c_fl_lane; fl_groups <= c_fl_grp;
            end else begin
                tk_vld <= '0; tk_warp <= '0; tk_lane <= '0; tk_groups <= '0;
                fl_vld <= '0; fl_warp <= '0; fl_lane <= '0; fl_groups <= '0;
            end
        end
    end

    assign stall_o = pending_q;

    // R1
    bypass_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_pls & stall_o) == '0);

    // R6
    cancel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (cancel_pls == '0));

    // R6
    group_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> ((int'(tk_groups) + int'(fl_groups)) < 2 * $countones(cmp_warps)));

    // R4
    slot_dense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (((tk_vld & (tk_vld + 1'b1)) == '0) && ((fl_vld & (fl_vld + 1'b1)) == '0)));

    // R2
    exit_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((release_pls | cancel_pls | cmp_warps) != '0) |->
        (((release_pls | cancel_pls | cmp_warps) & ~$past(stall_o)) == '0));
endmodule

// File: tb/sim_ws_compaction_ctrl.sv
module sim_ws_compaction_ctrl;
    localparam int W  = 4;
    localparam int L  = 8;
    localparam int NT = W * L;
    localparam int WB = 2;
    localparam int LB = 3;
    localparam int GW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]  arr_valid = '0;
    logic [NT-1:0] arr_taken = '0, arr_fall = '0;
    logic [W-1:0]  grp_member = '0, ready_vec = '1;
    logic [W-1:0]  stall_o, bypass_pls, cancel_pls, release_pls, cmp_warps;
    logic          cmp_valid;
    logic [NT-1:0] tk_vld, fl_vld;
    logic [NT*WB-1:0] tk_warp, fl_warp;
    logic [NT*LB-1:0] tk_lane, fl_lane;
    logic [GW-1:0] tk_groups, fl_groups;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1ACE_2B0D;
    logic [NT-1:0] acc_tk, acc_fl;
    logic [W-1:0]  exp_pend;

    always #5 clk = ~clk;

    ws_compaction_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_taken(arr_taken),
        .arr_fall(arr_fall), .grp_member(grp_member), .ready_vec(ready_vec),
        .stall_o(stall_o), .bypass_pls(bypass_pls), .cancel_pls(cancel_pls),
        .release_pls(release_pls), .cmp_valid(cmp_valid), .cmp_warps(cmp_warps),
        .tk_vld(tk_vld), .tk_warp(tk_warp), .tk_lane(tk_lane), .tk_groups(tk_groups),
        .fl_vld(fl_vld), .fl_warp(fl_warp), .fl_lane(fl_lane), .fl_groups(fl_groups));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Model of the packing rules (R4, R5).
    task automatic ref_pack(input logic [NT-1:0] m, output logic [NT-1:0] v,
                            output logic [NT*WB-1:0] wv, output logic [NT*LB-1:0] lv,
                            output int g);
        int k;
        k = 0; v = '0; wv = '0; lv = '0;
        for (int i = 0; i < NT; i++) begin
            if (m[i]) begin
                v[k] = 1'b1;
                wv[k*WB +: WB] = WB'(i / L);
                lv[k*LB +: LB] = LB'(i % L);
                k++;
            end
        end
        g = (k + L - 1) / L;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; arr_valid = '0; ready_vec = '1;
        acc_tk = '0; acc_fl = '0; exp_pend = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one arrival at a negedge; check bypass and stall after the edge (R1, R2).
    task automatic arrive(input int w, input logic [L-1:0] t, input logic [L-1:0] f);
        bit uni;
        uni = (t == '0) || (f == '0);
        arr_valid = '0; arr_valid[w] = 1'b1;
        arr_taken[w*L +: L] = t; arr_fall[w*L +: L] = f;
        @(negedge clk);
        arr_valid = '0;
        if (uni) begin
            check(bypass_pls == (W'(1) << w), "R1", "bypass pulse", bypass_pls, W'(1) << w);
        end else begin
            exp_pend[w] = 1'b1;
            acc_tk[w*L +: L] = t; acc_fl[w*L +: L] = f;
            check(bypass_pls == '0, "R1", "no bypass for divergent", bypass_pls, 0);
        end
        check(stall_o == exp_pend, "R2", "stall after arrival", stall_o, exp_pend);
    endtask

    // Check the gather outcome, one cycle after it fires (R3-R6).
    task automatic check_outcome();
        logic [NT-1:0] ev_t, ev_f;
        logic [NT*WB-1:0] ew_t, ew_f;
        logic [NT*LB-1:0] el_t, el_f;
        int gt, gf, np;
        bit canc;
        ref_pack(acc_tk, ev_t, ew_t, el_t, gt);
        ref_pack(acc_fl, ev_f, ew_f, el_f, gf);
        np = $countones(exp_pend);
        canc = (gt + gf) >= 2 * np;
        @(negedge clk);
        if (canc) begin
            check(cancel_pls == exp_pend && !cmp_valid, "R6", "cancel pulse",
                  {cmp_valid, cancel_pls}, {1'b0, exp_pend});
        end else begin
            check(cmp_valid && cmp_warps == exp_pend && cancel_pls == '0, "R3",
                  "packed result valid", {cmp_valid, cmp_warps}, {1'b1, exp_pend});
            check(tk_vld == ev_t && tk_warp == ew_t && tk_lane == el_t, "R4",
                  "taken slots", {tk_vld, tk_lane}, {ev_t, el_t});
            check(fl_vld == ev_f && fl_warp == ew_f && fl_lane == el_f, "R4",
                  "fall slots", {fl_vld, fl_lane}, {ev_f, el_f});
            check(int'(tk_groups) == gt && int'(fl_groups) == gf, "R5", "group counts",
                  {tk_groups, fl_groups}, {GW'(gt), GW'(gf)});
        end
        check(stall_o == '0, "R2", "stall cleared on fire", stall_o, 0);
        @(negedge clk);
        check(!cmp_valid && cancel_pls == '0, "R9", "single-cycle outcome",
              {cmp_valid, cancel_pls}, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(stall_o == '0 && bypass_pls == '0 && cancel_pls == '0 && release_pls == '0
              && !cmp_valid, "R9", "reset state", {stall_o, bypass_pls, cmp_valid}, 0);
    endtask

    task automatic t_all_uniform();
        do_reset();
        grp_member = 4'b1111;
        arrive(0, 8'hFF, 8'h00);
        arrive(1, 8'h00, 8'h3C);
        arrive(2, 8'h00, 8'h00);
        arrive(3, 8'h81, 8'h00);
        check(bypass_pls == 4'b1000, "R1", "last bypass", bypass_pls, 4'b1000);
        @(negedge clk);
        check(bypass_pls == '0 && !cmp_valid && cancel_pls == '0 && stall_o == '0, "R9",
              "uniform set leaves no pulse", {bypass_pls, cmp_valid, stall_o}, 0);
    endtask

    task automatic t_single_divergent();
        do_reset();
        grp_member = 4'b0010;
        arrive(1, 8'h3C, 8'hC3);
        check_outcome();
    endtask

    task automatic t_full_pack();
        do_reset();
        grp_member = 4'b1111;
        for (int w = 0; w < W; w++) begin
            arrive(w, 8'hF0, 8'h0F);
            if (w < W - 1)
                check(!cmp_valid, "R3", "no fire before all arrive", cmp_valid, 0);
        end
        check_outcome();
    endtask

    task automatic t_random(input int iters);
        for (int it = 0; it < iters; it++) begin
            logic [31:0] r;
            do_reset();
            r = rnd();
            grp_member = (r[3:0] == 0) ? 4'b0101 : r[3:0];
            for (int w = 0; w < W; w++) begin
                if (grp_member[w]) begin
                    logic [31:0] a;
                    logic [L-1:0] t, f;
                    a = rnd();
                    if (a[20:19] == 2'b00) begin
                        t = a[7:0] | 8'h01; f = '0;
                        if (a[21]) begin f = t; t = '0; end
                    end else begin
                        t = (a[7:0] | 8'h01) & 8'h7F;
                        f = ~t & (a[15:8] | 8'h80);
                    end
                    arrive(w, t, f);
                end
            end
            if (exp_pend != '0) check_outcome();
            else begin
                @(negedge clk);
                check(!cmp_valid && cancel_pls == '0, "R1", "uniform-only round",
                      {cmp_valid, cancel_pls}, 0);
            end
        end
    endtask

    task automatic t_release();
        do_reset();
        grp_member = 4'b0011;
        ready_vec = 4'b0100;
        arrive(0, 8'h0F, 8'hF0);
        repeat (3) @(negedge clk);
        check(stall_o == 4'b0001 && release_pls == '0, "R7", "held while other ready",
              {stall_o, release_pls}, 8'h10);
        ready_vec = 4'b0000;
        @(negedge clk);
        check(release_pls == 4'b0001 && stall_o == '0 && !cmp_valid && cancel_pls == '0,
              "R7", "release when nothing ready", {release_pls, stall_o}, 8'h10);
        @(negedge clk);
        check(release_pls == '0, "R9", "release single cycle", release_pls, 0);
        ready_vec = '1;
    endtask

    task automatic t_timeout();
        bit quiet;
        do_reset();
        grp_member = 4'b0011;
        arrive(0, 8'h55, 8'hAA);
        quiet = 1;
        for (int c = 1; c < 16; c++) begin
            @(negedge clk);
            if (cmp_valid || cancel_pls != '0 || stall_o != 4'b0001) quiet = 0;
        end
        check(quiet, "R8", "no fire before timeout", quiet, 1);
        @(negedge clk);
        check(cancel_pls == 4'b0001 && stall_o == '0, "R8", "timeout fires",
              {cancel_pls, stall_o}, 8'h10);
    endtask

    initial begin
        t_reset_state();
        t_all_uniform();
        t_single_divergent();
        t_full_pack();
        t_release();
        t_timeout();
        t_random(40);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule